// File: doc/BRIEF.md
# Command Slot Ring with Ordered Retirement

This block keeps a small ring of command-packet slots and the three counters that walk it: an allocation (write) index, a dispatch index and a retire (read) index. A fetch engine asks for a number of slots and receives a grant that is cut down to however many are free. It then loads each granted slot with a header type code and the host address the packet came from. A dispatch engine consumes slots one at a time from the dispatch index while it trails the write index. The dispatch port shows the header type and host address of the slot at the dispatch index.

Executing units report completions for dispatched slots in any order. The retire index moves only across an unbroken run of completed slots that starts at its current position. A whole run retires in the clock edge of the completion that closes the gap. Retired slots have their header returned to the invalid code. A one-cycle response tells the caller whether the completion moved the retire index, so the new value is pushed back to the host only when it changed. A completion naming a slot that is not both dispatched and unretired is dropped and flagged.

Top module: `pkt_ring`

## Requirements
- R1: After reset, all three indices read zero, the free count equals the depth, dispatch is not pending, and the slot at the dispatch index shows the invalid header code (default 1).
- R2: An allocation request for zero slots grants zero and leaves the write index unchanged.
- R3: While the request is high, the grant (combinational) is the smaller of the requested count and the free count. The free count is the depth minus (write index minus read index). `alloc_base` shows the slot at the current write index. The write index grows by the grant at the clock edge.
- R4: A fill write stores a header code and a host address into the named slot. Both are presented on the dispatch outputs when that slot is at the dispatch index.
- R5: Dispatch is pending exactly when the dispatch index differs from the write index. An accept while pending advances the dispatch index by one. An accept while not pending has no effect.
- R6: A completion for a slot that is not at the read index records the slot as done but does not move the read index; the moved response stays low.
- R7: A completion that makes the slot at the read index done retires the full contiguous run of done slots in one edge. The read index advances by the run length, and `cmpl_moved` is high for the single following cycle.
- R8: Every retired slot's header returns to the invalid code.
- R9: A completion for a slot outside the window from the read index up to the dispatch index is ignored: `cmpl_err` pulses for one cycle, the read index is unchanged, and the slot is not recorded as done.
- R10: Indices are free-running counters one bit wider than the slot number (default 5 bits) and wrap modulo twice the depth. The slot is the low bits. A full ring grants zero.
- R11: An allocation and a completion in the same cycle both take effect. The grant uses the free count from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_num | input | log2(DEPTH)+1 | Number of slots requested |
| alloc_grant | output | log2(DEPTH)+1 | Slots granted this cycle |
| alloc_base | output | log2(DEPTH) | First slot of the grant (slot at write index) |
| free_cnt | output | log2(DEPTH)+1 | Number of free slots |
| fill_valid | input | 1 | Slot load strobe |
| fill_slot | input | log2(DEPTH) | Slot to load |
| fill_type | input | HDR_W | Header type code to store |
| fill_addr | input | ADDR_W | Host address to store |
| disp_pending | output | 1 | A slot awaits dispatch |
| disp_accept | input | 1 | Dispatcher takes the slot at the dispatch index |
| disp_slot | output | log2(DEPTH) | Slot at the dispatch index |
| disp_type | output | HDR_W | Header code of that slot |
| disp_addr | output | ADDR_W | Host address of that slot |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_slot | input | log2(DEPTH) | Completed slot |
| cmpl_moved | output | 1 | Previous completion advanced the read index |
| cmpl_err | output | 1 | Previous completion was outside the window |
| rd_idx | output | log2(DEPTH)+1 | Retire index |
| wr_idx | output | log2(DEPTH)+1 | Allocation index |
| disp_idx | output | log2(DEPTH)+1 | Dispatch index |

## Verification
Allocation and retirement can land on the same edge. One moves the write index and the other the read index, and the grant must use the free count from before the edge. The bench fills the ring, frees a single slot, then raises a request for four slots in the same cycle as a completion at the head. It expects a grant of one, with both indices advancing afterwards. A long run is also closed by one completion across the index wrap. This checks that the multi-slot retirement and the wrapped free count agree.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;

   typedef struct packed {
      logic moved;
      logic err;
   } cmpl_resp_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pkt_ring_alloc.sv
module pkt_ring_alloc #(
   parameter int DEPTH = 16,
   parameter int SLOTW = $clog2(DEPTH),
   parameter int CNTW  = SLOTW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [CNTW-1:0] num,
   input  logic [CNTW-1:0] rd_idx,
   output logic [CNTW-1:0] grant,
   output logic [CNTW-1:0] wr_idx,
   output logic [CNTW-1:0] free_cnt
);
   localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

   logic [CNTW-1:0] wr_q;
   logic [CNTW-1:0] occ;

   assign occ      = wr_q - rd_idx;
   assign free_cnt = FULL - occ;
   assign grant    = !req ? '0 : ((num > free_cnt) ? free_cnt : num);
   assign wr_idx   = wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_q <= '0;
      else        wr_q <= wr_q + grant;
   end

   // R3
   grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant <= free_cnt) && (grant <= num || !req));
   // R2
   zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && num == '0) |=> $stable(wr_q));
   // R10
   occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= FULL);

endmodule

// File: rtl/pkt_ring_retire.sv
module pkt_ring_retire
   import pkt_ring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int SLOTW = $clog2(DEPTH),
   parameter int CNTW  = SLOTW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmpl_valid,
   input  logic [SLOTW-1:0] cmpl_slot,
   input  logic [CNTW-1:0]  disp_idx,
   output logic [CNTW-1:0]  rd_idx,
   output logic [DEPTH-1:0] clr_mask,
   output cmpl_resp_t       resp
);
   logic [DEPTH-1:0] done_q;
   logic [DEPTH-1:0] done_eff;
   logic [CNTW-1:0]  rd_q;
   logic [CNTW-1:0]  inflight;
   logic [CNTW-1:0]  run_len;
   logic [SLOTW-1:0] offs;
   logic [SLOTW-1:0] probe;
   logic             in_win;
   logic             hit;
   logic             cont;
   cmpl_resp_t       resp_q;

   assign inflight = disp_idx - rd_q;
   assign offs     = cmpl_slot - rd_q[SLOTW-1:0];
   assign in_win   = CNTW'(offs) < inflight;
   assign hit      = cmpl_valid && in_win;

   always_comb begin
      done_eff = done_q;
      if (hit) done_eff[cmpl_slot] = 1'b1;
      clr_mask = '0;
      run_len  = '0;
      cont     = hit;
      probe    = '0;
      for (int i = 0; i < DEPTH; i++) begin
         probe = rd_q[SLOTW-1:0] + SLOTW'(i);
         if (cont && done_eff[probe]) begin
            clr_mask[probe] = 1'b1;
            run_len         = run_len + 1'b1;
         end else begin
            cont = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= '0;
         rd_q   <= '0;
         resp_q <= '0;
      end else begin
         done_q       <= done_eff & ~clr_mask;
         rd_q         <= rd_q + run_len;
         resp_q.moved <= (run_len != '0);
         resp_q.err   <= cmpl_valid && !in_win;
      end
   end

   assign rd_idx = rd_q;
   assign resp   = resp_q;

   // R9
   stray_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && !in_win) |=> (resp_q.err && !resp_q.moved && $stable(rd_q)));
   // R7
   moved_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_q.moved |-> (rd_q != $past(rd_q)));
   // R6
   no_cmpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmpl_valid |=> $stable(rd_q));
   // R7
   rd_behind_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CNTW'(DEPTH));

endmodule

// File: rtl/pkt_ring_slots.sv
module pkt_ring_slots #(
   parameter int             DEPTH       = 16,
   parameter int             SLOTW       = $clog2(DEPTH),
   parameter int             HDR_W       = 8,
   parameter int             ADDR_W      = 48,
   parameter logic [HDR_W-1:0] INVALID_HDR = HDR_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOTW-1:0]  wr_slot,
   input  logic [HDR_W-1:0]  wr_type,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DEPTH-1:0]  clr_mask,
   input  logic [SLOTW-1:0]  rd_slot,
   output logic [HDR_W-1:0]  rd_type,
   output logic [ADDR_W-1:0] rd_addr
);
   logic [DEPTH-1:0][HDR_W-1:0]  hdr_all;
   logic [DEPTH-1:0][ADDR_W-1:0] adr_all;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [HDR_W-1:0]  hdr;
      logic [ADDR_W-1:0] adr;
      logic              sel;

      assign sel = wr_en && (wr_slot == SLOTW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hdr <= INVALID_HDR;
            adr <= '0;
         end else if (sel) begin
            hdr <= wr_type;
            adr <= wr_addr;
         end else if (clr_mask[g]) begin
            hdr <= INVALID_HDR;
         end
      end

      assign hdr_all[g] = hdr;
      assign adr_all[g] = adr;

      // R8
      retire_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[g] && !sel) |=> (hdr == INVALID_HDR));
   end

   assign rd_type = hdr_all[rd_slot];
   assign rd_addr = adr_all[rd_slot];

endmodule

// File: rtl/pkt_ring.sv
module pkt_ring
   import pkt_ring_pkg::*;
#(
   parameter int               DEPTH       = 16,
   parameter int               HDR_W       = 8,
   parameter int               ADDR_W      = 48,
   parameter logic [HDR_W-1:0] INVALID_HDR = HDR_W'(1),
   localparam int              SLOTW       = $clog2(DEPTH),
   localparam int              CNTW        = SLOTW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [CNTW-1:0]   alloc_num,
   output logic [CNTW-1:0]   alloc_grant,
   output logic [SLOTW-1:0]  alloc_base,
   output logic [CNTW-1:0]   free_cnt,
   input  logic              fill_valid,
   input  logic [SLOTW-1:0]  fill_slot,
   input  logic [HDR_W-1:0]  fill_type,
   input  logic [ADDR_W-1:0] fill_addr,
   output logic              disp_pending,
   input  logic              disp_accept,
   output logic [SLOTW-1:0]  disp_slot,
   output logic [HDR_W-1:0]  disp_type,
   output logic [ADDR_W-1:0] disp_addr,
   input  logic              cmpl_valid,
   input  logic [SLOTW-1:0]  cmpl_slot,
   output logic              cmpl_moved,
   output logic              cmpl_err,
   output logic [CNTW-1:0]   rd_idx,
   output logic [CNTW-1:0]   wr_idx,
   output logic [CNTW-1:0]   disp_idx
);
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("pkt_ring: DEPTH must be a power of two, at least 2");
   end
   if (HDR_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("pkt_ring: header and address widths must be positive");
   end

   logic [CNTW-1:0]  wr_w;
   logic [CNTW-1:0]  rd_w;
   logic [CNTW-1:0]  disp_q;
   logic [DEPTH-1:0] clr_w;
   cmpl_resp_t       resp_w;

   pkt_ring_alloc #(.DEPTH(DEPTH), .SLOTW(SLOTW), .CNTW(CNTW)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (alloc_req),
      .num      (alloc_num),
      .rd_idx   (rd_w),
      .grant    (alloc_grant),
      .wr_idx   (wr_w),
      .free_cnt (free_cnt)
   );

   pkt_ring_retire #(.DEPTH(DEPTH), .SLOTW(SLOTW), .CNTW(CNTW)) u_retire (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmpl_valid (cmpl_valid),
      .cmpl_slot  (cmpl_slot),
      .disp_idx   (disp_q),
      .rd_idx     (rd_w),
      .clr_mask   (clr_w),
      .resp       (resp_w)
   );

   pkt_ring_slots #(
      .DEPTH(DEPTH), .SLOTW(SLOTW), .HDR_W(HDR_W),
      .ADDR_W(ADDR_W), .INVALID_HDR(INVALID_HDR)
   ) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_valid),
      .wr_slot  (fill_slot),
      .wr_type  (fill_type),
      .wr_addr  (fill_addr),
      .clr_mask (clr_w),
      .rd_slot  (disp_q[SLOTW-1:0]),
      .rd_type  (disp_type),
      .rd_addr  (disp_addr)
   );

   assign disp_pending = (disp_q != wr_w);

   always_ff @(posedge clk) begin
      if (!rst_n)                          disp_q <= '0;
      else if (disp_accept && disp_pending) disp_q <= disp_q + 1'b1;
   end

   assign alloc_base = wr_w[SLOTW-1:0];
   assign disp_slot  = disp_q[SLOTW-1:0];
   assign disp_idx   = disp_q;
   assign rd_idx     = rd_w;
   assign wr_idx     = wr_w;
   assign cmpl_moved = resp_w.moved;
   assign cmpl_err   = resp_w.err;

   // R5
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_accept && !disp_pending) |=> $stable(disp_q));
   // R10
   index_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w - disp_q) <= (wr_w - rd_w));
   // R7
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cmpl_moved, cmpl_err}) <= 1);

endmodule

// File: tb/test_pkt_ring.sv
module test_pkt_ring;
   localparam int DEPTH = 16, SLOTW = 4, CNTW = 5, HDR_W = 8, ADDR_W = 48;
   localparam logic [HDR_W-1:0] INV = 8'd1;
   localparam logic [HDR_W-1:0] TYP = 8'd2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              alloc_req;
   logic [CNTW-1:0]   alloc_num;
   logic [CNTW-1:0]   alloc_grant;
   logic [SLOTW-1:0]  alloc_base;
   logic [CNTW-1:0]   free_cnt;
   logic              fill_valid;
   logic [SLOTW-1:0]  fill_slot;
   logic [HDR_W-1:0]  fill_type;
   logic [ADDR_W-1:0] fill_addr;
   logic              disp_pending;
   logic              disp_accept;
   logic [SLOTW-1:0]  disp_slot;
   logic [HDR_W-1:0]  disp_type;
   logic [ADDR_W-1:0] disp_addr;
   logic              cmpl_valid;
   logic [SLOTW-1:0]  cmpl_slot;
   logic              cmpl_moved;
   logic              cmpl_err;
   logic [CNTW-1:0]   rd_idx;
   logic [CNTW-1:0]   wr_idx;
   logic [CNTW-1:0]   disp_idx;

   pkt_ring #(.DEPTH(DEPTH), .HDR_W(HDR_W), .ADDR_W(ADDR_W), .INVALID_HDR(INV)) i_pkt_ring (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_num(alloc_num), .alloc_grant(alloc_grant),
      .alloc_base(alloc_base), .free_cnt(free_cnt),
      .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_type(fill_type), .fill_addr(fill_addr),
      .disp_pending(disp_pending), .disp_accept(disp_accept), .disp_slot(disp_slot),
      .disp_type(disp_type), .disp_addr(disp_addr),
      .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .cmpl_moved(cmpl_moved), .cmpl_err(cmpl_err),
      .rd_idx(rd_idx), .wr_idx(wr_idx), .disp_idx(disp_idx)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic idle_inputs();
      alloc_req = 0; alloc_num = '0; fill_valid = 0; fill_slot = '0;
      fill_type = '0; fill_addr = '0; disp_accept = 0; cmpl_valid = 0; cmpl_slot = '0;
   endtask

   task automatic do_alloc(input int num, input int exp_grant, input int exp_base);
      alloc_req = 1; alloc_num = CNTW'(num);
      #1;
      chk("R3 grant", alloc_grant, exp_grant);
      chk("R3 base", alloc_base, exp_base);
      tick();
      alloc_req = 0; alloc_num = '0;
   endtask

   task automatic do_fill(input int slot, input logic [HDR_W-1:0] t, input logic [ADDR_W-1:0] a);
      fill_valid = 1; fill_slot = SLOTW'(slot); fill_type = t; fill_addr = a;
      tick();
      fill_valid = 0;
   endtask

   task automatic do_accept();
      disp_accept = 1;
      tick();
      disp_accept = 0;
   endtask

   task automatic do_cmpl(input int slot);
      cmpl_valid = 1; cmpl_slot = SLOTW'(slot);
      tick();
      cmpl_valid = 0;
   endtask

   task automatic t_reset();
      chk("R1 rd", rd_idx, 0);
      chk("R1 wr", wr_idx, 0);
      chk("R1 disp", disp_idx, 0);
      chk("R1 free", free_cnt, DEPTH);
      chk("R1 pending", disp_pending, 0);
      chk("R1 type", disp_type, INV);
   endtask

   task automatic t_zero_alloc();
      do_alloc(0, 0, 0);
      chk("R2 wr unchanged", wr_idx, 0);
   endtask

   task automatic t_alloc_fill();
      do_alloc(5, 5, 0);
      chk("R3 wr", wr_idx, 5);
      chk("R3 free", free_cnt, 11);
      for (int i = 0; i < 5; i++) do_fill(i, TYP, 48'h1000 + ADDR_W'(i));
   endtask

   task automatic t_dispatch();
      for (int i = 0; i < 5; i++) begin
         chk("R5 pending", disp_pending, 1);
         chk("R4 type", disp_type, TYP);
         chk("R4 addr", disp_addr, 48'h1000 + ADDR_W'(i));
         do_accept();
      end
      chk("R5 idle", disp_pending, 0);
      do_accept();
      chk("R5 ignored accept", disp_idx, 5);
   endtask

   task automatic t_out_of_order();
      do_cmpl(2);
      chk("R6 moved", cmpl_moved, 0);
      chk("R6 err", cmpl_err, 0);
      chk("R6 rd", rd_idx, 0);
      do_cmpl(1);
      chk("R6 rd still", rd_idx, 0);
      do_cmpl(0);
      chk("R7 moved", cmpl_moved, 1);
      chk("R7 rd run", rd_idx, 3);
      tick();
      chk("R7 pulse ends", cmpl_moved, 0);
   endtask

   task automatic t_window();
      do_cmpl(7);
      chk("R9 err", cmpl_err, 1);
      chk("R9 moved", cmpl_moved, 0);
      chk("R9 rd", rd_idx, 3);
      tick();
      chk("R9 err pulse", cmpl_err, 0);
      do_cmpl(4);
      chk("R6 rd", rd_idx, 3);
      do_cmpl(3);
      chk("R7 rd", rd_idx, 5);
      do_alloc(4, 4, 5);
      for (int i = 0; i < 4; i++) do_accept();
      chk("R5 disp", disp_idx, 9);
      do_cmpl(6);
      chk("R6 rd", rd_idx, 5);
      do_cmpl(5);
      chk("R9 stray slot not done", rd_idx, 7);
      do_cmpl(8);
      do_cmpl(7);
      chk("R7 rd", rd_idx, 9);
   endtask

   task automatic t_wrap_concurrent();
      int moved_cnt;
      do_alloc(20, 16, 9);
      chk("R10 full", free_cnt, 0);
      do_alloc(3, 0, 9);
      for (int i = 0; i < 16; i++) begin
         chk("R8 retired header invalid", disp_type, INV);
         do_accept();
      end
      chk("R10 disp wrap", disp_idx, 25);
      do_cmpl(9);
      chk("R7 rd", rd_idx, 10);
      chk("R10 free", free_cnt, 1);
      // R11: allocation and completion in the same cycle
      alloc_req = 1; alloc_num = CNTW'(4); cmpl_valid = 1; cmpl_slot = SLOTW'(10);
      #1;
      chk("R11 grant old free", alloc_grant, 1);
      chk("R11 base", alloc_base, 9);
      tick();
      alloc_req = 0; cmpl_valid = 0;
      chk("R11 wr", wr_idx, 26);
      chk("R11 rd", rd_idx, 11);
      chk("R11 moved", cmpl_moved, 1);
      chk("R11 free", free_cnt, 1);
      moved_cnt = 0;
      for (int s = 8; s >= 0; s--) begin
         do_cmpl(s);
         moved_cnt += int'(cmpl_moved);
      end
      for (int s = 15; s >= 12; s--) begin
         do_cmpl(s);
         moved_cnt += int'(cmpl_moved);
      end
      chk("R6 no moves before head", moved_cnt, 0);
      chk("R6 rd held", rd_idx, 11);
      do_cmpl(11);
      chk("R7 long run moved", cmpl_moved, 1);
      chk("R10 rd wrap", rd_idx, 25);
      chk("R10 free", free_cnt, 15);
      chk("R10 base", alloc_base, 10);
      chk("R5 pending", disp_pending, 1);
   endtask

   initial begin
      #(8 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1;
      tick();
      t_reset();
      t_zero_alloc();
      t_alloc_fill();
      t_dispatch();
      t_out_of_order();
      t_window();
      t_wrap_concurrent();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule